// File: doc/BRIEF.md
# I2C Serial Clock Generator

This block makes the serial clock (SCL) for an I2C master from a fast system clock. A programmable prescaler first divides the system clock into a module-clock enable. The low and high halves of SCL are then timed separately, counted in module-clock periods. The length of each half is its programmed count plus a small fixed offset, and the prescaler setting decides which offset applies. Because the two halves are programmed on their own, the duty cycle does not have to be 50%.

The master controller raises `run` to request clock cycles. A clock pulse in progress always completes, and SCL idles high. A one-cycle strobe marks each falling and each rising SCL edge, for the logic that shifts the data. The enable bit holds the block in reset while it is clear. The prescaler value must be written before the block is released. A new low or high count only takes effect at the next phase boundary.

Top module: `scl_clkgen`

## Requirements
- R1: While a clock is running, the prescaler produces one module-clock tick every (P+1) system clocks, where P is the captured prescaler value.
- R2: The offset d is 7 when P = 0, 6 when P = 1, and 5 when P is 2 or greater.
- R3: SCL stays low for exactly (L+d)*(P+1) system clocks, where L is the low count loaded at the start of that phase.
- R4: SCL stays high between two pulses for exactly (H+d)*(P+1) system clocks, where H is the high count loaded at the start of that phase.
- R5: While `mod_en` is 0, SCL is 1 and both strobes are 0 from the next clock onward. `psc_val` is captured only while `mod_en` is 0, so a change made while the block is enabled has no effect on the phase lengths.
- R6: While the generator is idle and `run` is 0, SCL stays 1. If `run` is 1 at a clock edge while the generator is idle, SCL is 0 in the cycle that follows that edge.
- R7: A change to `low_cnt` or `high_cnt` never alters a phase that has already started. The new value applies from the next phase of that kind.
- R8: `fall_stb` is 1 for exactly the first cycle in which SCL is 0. `rise_stb` is 1 for exactly the first cycle in which SCL is 1 after a low phase. The two strobes are never 1 together.
- R9: If `run` is 0 when a high phase ends, SCL stays high and the generator goes idle. A low phase that is already under way always completes, followed by its full high phase.
- R10: `rst` is a synchronous, active-high reset. It leaves SCL at 1 with both strobes at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_en | input | 1 | Module enable; 0 holds the block in reset |
| psc_val | input | PSC_W | Prescaler value P |
| low_cnt | input | CNT_W | Low-phase count L |
| high_cnt | input | CNT_W | High-phase count H |
| run | input | 1 | Request for clock pulses from the master |
| scl_o | output | 1 | Serial clock |
| fall_stb | output | 1 | One-cycle strobe on the SCL falling edge |
| rise_stb | output | 1 | One-cycle strobe on the SCL rising edge |

## Verification
Three things can happen at the same clock edge: a count register write, the boundary of the phase that will load it, and a drop in `run`. The bench provokes this by rewriting both counts in the first cycle of a low phase. It then checks that this phase keeps its old length, and that the following high and low phases take the new values. In a separate case, `run` falls during a low phase. The bench checks that SCL completes that pulse and its full high phase before it goes idle, and that no further falling strobe appears.

// File: rtl/scl_pkg.sv
package scl_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    localparam int OFS_W = 3;

    // Phase-length offset chosen by the prescaler setting
    function automatic logic [OFS_W-1:0] offset_for(input logic psc_is0, input logic psc_is1);
        if (psc_is0)      return OFS_W'(7);
        else if (psc_is1) return OFS_W'(6);
        else              return OFS_W'(5);
    endfunction

endpackage

// File: rtl/scl_cfg_hold.sv
module scl_cfg_hold #(
    parameter int PSC_W = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         en,
    input  logic [PSC_W-1:0]             psc_in,
    output logic [PSC_W-1:0]             psc_sh,
    output logic [scl_pkg::OFS_W-1:0]    ofs
);
    // Prescaler value and offset are followed only while held in reset
    always_ff @(posedge clk) begin
        if (rst || !en) begin
            psc_sh <= psc_in;
            ofs    <= scl_pkg::offset_for(psc_in == '0, psc_in == PSC_W'(1));
        end
    end

    AST_PSC_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en)) |-> $stable(psc_sh)); // R5

    AST_OFS_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (ofs >= scl_pkg::OFS_W'(5)) && (ofs <= scl_pkg::OFS_W'(7))); // R2

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             active,
    input  logic             restart,
    input  logic [PSC_W-1:0] psc_sh,
    output logic             tick
);
    logic [PSC_W-1:0] pcnt;

    assign tick = active && (pcnt == '0);

    always_ff @(posedge clk) begin
        if (clr)             pcnt <= '0;
        else if (restart)    pcnt <= psc_sh;
        else if (!active)    pcnt <= '0;
        else if (pcnt == '0) pcnt <= psc_sh;
        else                 pcnt <= pcnt - PSC_W'(1);
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (clr)
        (tick && psc_sh != '0 && !restart) |=> !tick); // R1

endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq #(
    parameter int CNT_W = 8,
    localparam int REM_W = CNT_W + 1
) (
    input  logic                       clk,
    input  logic                       clr,
    input  logic                       run,
    input  logic                       tick,
    input  logic [CNT_W-1:0]           low_cnt,
    input  logic [CNT_W-1:0]           high_cnt,
    input  logic [scl_pkg::OFS_W-1:0]  ofs,
    output logic                       active,
    output logic                       go,
    output logic                       scl,
    output logic                       fall_stb,
    output logic                       rise_stb
);
    import scl_pkg::*;

    phase_e            phase;
    logic [REM_W-1:0]  rem;
    logic              last;
    logic [REM_W-1:0]  low_load;
    logic [REM_W-1:0]  high_load;

    // Remaining ticks minus one: count + offset - 1
    assign low_load  = REM_W'(low_cnt)  + REM_W'(ofs) - REM_W'(1);
    assign high_load = REM_W'(high_cnt) + REM_W'(ofs) - REM_W'(1);

    assign active = (phase != PH_IDLE);
    assign go     = (phase == PH_IDLE) && run;
    assign last   = tick && (rem == '0);
    assign scl    = (phase != PH_LOW);

    always_ff @(posedge clk) begin
        if (clr) begin
            phase    <= PH_IDLE;
            rem      <= '0;
            fall_stb <= 1'b0;
            rise_stb <= 1'b0;
        end else begin
            fall_stb <= 1'b0;
            rise_stb <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (run) begin
                        phase    <= PH_LOW;
                        rem      <= low_load;
                        fall_stb <= 1'b1;
                    end
                end
                PH_LOW: begin
                    if (last) begin
                        phase    <= PH_HIGH;
                        rem      <= high_load;
                        rise_stb <= 1'b1;
                    end else if (tick) begin
                        rem <= rem - REM_W'(1);
                    end
                end
                PH_HIGH: begin
                    if (last) begin
                        if (run) begin
                            phase    <= PH_LOW;
                            rem      <= low_load;
                            fall_stb <= 1'b1;
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end else if (tick) begin
                        rem <= rem - REM_W'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    AST_FALL_ON_EDGE: assert property (@(posedge clk) disable iff (clr)
        fall_stb |-> (!scl && $past(scl))); // R8

    AST_RISE_ON_EDGE: assert property (@(posedge clk) disable iff (clr)
        rise_stb |-> (scl && !$past(scl))); // R8

    AST_STB_EXCL: assert property (@(posedge clk) disable iff (clr)
        $countones({fall_stb, rise_stb}) <= 1); // R8

    AST_IDLE_STAYS_HIGH: assert property (@(posedge clk) disable iff (clr)
        (!active && !run) |=> scl); // R6

    AST_LOW_HOLDS: assert property (@(posedge clk) disable iff (clr)
        (phase == PH_LOW && !last) |=> !scl); // R3

endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen #(
    parameter int PSC_W = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mod_en,
    input  logic [PSC_W-1:0] psc_val,
    input  logic [CNT_W-1:0] low_cnt,
    input  logic [CNT_W-1:0] high_cnt,
    input  logic             run,
    output logic             scl_o,
    output logic             fall_stb,
    output logic             rise_stb
);
    logic                       clr;
    logic [PSC_W-1:0]           psc_sh;
    logic [scl_pkg::OFS_W-1:0]  ofs;
    logic                       tick;
    logic                       active;
    logic                       go;

    assign clr = rst || !mod_en;

    scl_cfg_hold #(.PSC_W(PSC_W)) i_cfg (
        .clk    (clk),
        .rst    (rst),
        .en     (mod_en),
        .psc_in (psc_val),
        .psc_sh (psc_sh),
        .ofs    (ofs)
    );

    scl_prescaler #(.PSC_W(PSC_W)) i_psc (
        .clk     (clk),
        .clr     (clr),
        .active  (active),
        .restart (go),
        .psc_sh  (psc_sh),
        .tick    (tick)
    );

    scl_phase_seq #(.CNT_W(CNT_W)) i_seq (
        .clk      (clk),
        .clr      (clr),
        .run      (run),
        .tick     (tick),
        .low_cnt  (low_cnt),
        .high_cnt (high_cnt),
        .ofs      (ofs),
        .active   (active),
        .go       (go),
        .scl      (scl_o),
        .fall_stb (fall_stb),
        .rise_stb (rise_stb)
    );

    AST_HELD_RESET: assert property (@(posedge clk) disable iff (rst)
        !mod_en |=> (scl_o && !fall_stb && !rise_stb)); // R5

    AST_SYNC_RESET: assert property (@(posedge clk)
        rst |=> (scl_o && !fall_stb && !rise_stb)); // R10

endmodule

// File: tb/test_scl_clkgen.sv
module test_scl_clkgen;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 5000;

    typedef struct packed {
        logic [7:0]  psc;
        logic [7:0]  lo;
        logic [7:0]  hi;
        logic [15:0] elo;
        logic [15:0] ehi;
    } vec_t;

    // Expected lengths = (count + d) * (P + 1); d per R2
    localparam vec_t VECS [6] = '{
        '{8'd0,  8'd0, 8'd0, 16'd7,   16'd7},
        '{8'd0,  8'd3, 8'd1, 16'd10,  16'd8},
        '{8'd1,  8'd2, 8'd4, 16'd16,  16'd20},
        '{8'd2,  8'd0, 8'd3, 16'd15,  16'd24},
        '{8'd13, 8'd5, 8'd5, 16'd140, 16'd140},
        '{8'd3,  8'd1, 8'd0, 16'd24,  16'd20}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mod_en = 1'b0;
    logic [7:0] psc_val = '0;
    logic [7:0] low_cnt = '0;
    logic [7:0] high_cnt = '0;
    logic       run = 1'b0;
    logic       scl_o;
    logic       fall_stb;
    logic       rise_stb;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scl_clkgen i_scl_clkgen (
        .clk      (clk),
        .rst      (rst),
        .mod_en   (mod_en),
        .psc_val  (psc_val),
        .low_cnt  (low_cnt),
        .high_cnt (high_cnt),
        .run      (run),
        .scl_o    (scl_o),
        .fall_stb (fall_stb),
        .rise_stb (rise_stb)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic count_low(output int n);
        n = 0;
        while (scl_o == 1'b0 && n < LIMIT) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic count_high(output int n);
        n = 0;
        while (scl_o == 1'b1 && n < LIMIT) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic setup(input logic [7:0] p, input logic [7:0] l, input logic [7:0] h);
        mod_en   = 1'b0;
        run      = 1'b0;
        psc_val  = p;
        low_cnt  = l;
        high_cnt = h;
        repeat (2) @(negedge clk);
        mod_en = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int n;
        int bad;
        repeat (3) @(negedge clk);
        chk("R10 scl in reset", scl_o, 1);
        chk("R10 strobes in reset", fall_stb | rise_stb, 0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < 6; i++) begin
            setup(VECS[i].psc, VECS[i].lo, VECS[i].hi);
            repeat (3) @(negedge clk);
            chk("R6 idle high", scl_o, 1);
            run = 1'b1;
            @(negedge clk);
            chk("R6 start low", scl_o, 0);
            chk("R8 fall strobe", fall_stb, 1);
            count_low(n);
            chk("R3 R1 R2 low length", n, VECS[i].elo);
            chk("R8 rise strobe", rise_stb, 1);
            count_high(n);
            chk("R4 R1 R2 high length", n, VECS[i].ehi);
            chk("R8 fall strobe again", fall_stb, 1);
            run = 1'b0;
            count_low(n);
            chk("R9 pulse completes low", n, VECS[i].elo);
            bad = 0;
            for (int k = 0; k < VECS[i].ehi + 20; k++) begin
                if (scl_o == 1'b0 || fall_stb) bad++;
                @(negedge clk);
            end
            chk("R9 idle after run drop", bad, 0);
        end

        // R7: counts rewritten in the first low cycle
        setup(8'd0, 8'd2, 8'd2);
        run = 1'b1;
        @(negedge clk);
        low_cnt  = 8'd10;
        high_cnt = 8'd0;
        count_low(n);
        chk("R7 running low unchanged", n, 9);
        count_high(n);
        chk("R7 new high count", n, 7);
        count_low(n);
        chk("R7 new low count", n, 17);
        run = 1'b0;
        repeat (30) @(negedge clk);

        // R5: prescaler change while enabled is ignored
        setup(8'd1, 8'd0, 8'd0);
        run = 1'b1;
        @(negedge clk);
        psc_val = 8'd0;
        count_low(n);
        chk("R5 psc ignored low", n, 12);
        count_high(n);
        chk("R5 psc ignored high", n, 12);
        repeat (3) @(negedge clk);
        chk("R5 in low before disable", scl_o, 0);
        mod_en = 1'b0;
        @(negedge clk);
        chk("R5 disable forces high", scl_o, 1);
        chk("R5 disable clears strobes", fall_stb | rise_stb, 0);
        run = 1'b0;

        // R10: reset during a low phase
        setup(8'd0, 8'd4, 8'd4);
        run = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 low before reset", scl_o, 0);
        rst = 1'b1;
        @(negedge clk);
        chk("R10 reset forces high", scl_o, 1);
        chk("R10 reset clears strobes", fall_stb | rise_stb, 0);
        rst = 1'b0;
        run = 1'b0;
        repeat (2) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule